// File: doc/BRIEF.md
# Pulse-and-Verify Programming Sequencer

This block burns a run of consecutive words into a one-time-programmable memory. A single start command supplies a base address and a word count. For each address the sequencer fetches one word from a data source. It presents the address and the word to the memory, then repeats a cycle of a program pulse followed by a read-back. It stops pulsing an address as soon as the read-back matches the word. If a word still does not read back correctly after a bounded number of pulses, the run aborts.

While a run is active, the sequencer holds the memory selected and raises a flag that asks for the programming supply. Each program pulse is a fixed number of clock cycles long, active low, and set by a parameter. The default is about 100 microseconds at 200 MHz. A fixed gap separates every change of address or data from the pulse, and every pulse from the read-back. At the end, a single-cycle done strobe reports pass or fail together with the address that failed. The supply flag drops in the same cycle.

Top module: `otp_burn_seq`

## Requirements
- R1: Out of reset and whenever idle, `busy` and `done` are 0, `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` are 1, and `mem_vpp_hi` and `mem_wdata_en` are 0.
- R2: From an accepted start until the done cycle, `mem_vpp_hi` is 1 and `mem_ce_n` is 0. In the done cycle, `mem_vpp_hi` is 0 and `mem_ce_n` is 1.
- R3: Every program pulse holds `mem_pgm_n` low for exactly PULSE_CYC cycles, and `mem_pgm_n` returns high between pulses.
- R4: `mem_addr` and `mem_wdata` (with `mem_wdata_en` 1) are settled SETUP_CYC cycles before a pulse and do not change while `mem_pgm_n` is low.
- R5: During read-back, `mem_oe_n` is 0, `mem_pgm_n` is 1 and `mem_wdata_en` is 0. `mem_pgm_n` and `mem_oe_n` are never low together.
- R6: Pulsing of an address ends at the first read-back that equals the word, and the next address is then started.
- R7: No address receives more than MAX_PULSES (default 25) pulses. A match on the last allowed pulse still counts as a pass.
- R8: If the read-back after the final allowed pulse mismatches, the run ends with `pass` = 0 and `fail_addr` = that address, and no later address is fetched or pulsed.
- R9: `done` is high for exactly one cycle per run. When every word verified, `pass` is 1 in that cycle.
- R10: A start with `word_count` = 0 gives `done` with `pass` = 1 and produces no pulse and no source read.
- R11: `start` is ignored while `busy` is 1.
- R12: Words are taken from the source one per address, in rising address order from `base_addr`. `src_rd` stays high until `src_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| base_addr | input | AW | First address of the run |
| word_count | input | AW+1 | Number of words to burn |
| src_rd | output | 1 | Request for the next word |
| src_valid | input | 1 | Source word present on src_data |
| src_data | input | DW | Word from the source |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Word driven to the memory data pins |
| mem_wdata_en | output | 1 | Drive enable for mem_wdata |
| mem_rdata | input | DW | Memory data pins read back |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| mem_vpp_hi | output | 1 | Request for the programming supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | All words verified (valid with done) |
| fail_addr | output | AW | Address that exhausted its pulses |

## Verification
The hardest case to reach is pulse exhaustion. In real use a cell nearly always verifies after one or two pulses, so the path through the maximum pulse count rarely occurs. The bench memory model gives each address its own count of pulses needed before its cells take the data. It can also pre-clear bits so that a requested 1 can never read back. Both behaviours force 25 pulses onto a chosen address. A neighbouring address needing exactly 25 pulses checks the boundary on the pass side.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_DONE
  } burn_state_t;
endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // An expired timer stays expired until it is reloaded (pulse width integrity).
  assert_timer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/burn_tally.sv
module burn_tally #(
  parameter int MAX = 25,
  parameter int W   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         at_max
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | inc;
  assign count  = cnt_q;
  assign at_max = (cnt_q == W'(MAX));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_tally_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(MAX));
  assert_no_inc_past_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr) |-> !inc);
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_burn_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int PULSE_CYC  = 20000,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int VERIFY_CYC = 2,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW:0]   word_count,
  output logic          src_rd,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_en,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_pgm_n,
  output logic          mem_vpp_hi,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr
);
  localparam int CYC_SUM = PULSE_CYC + SETUP_CYC + HOLD_CYC + VERIFY_CYC;
  localparam int TW      = $clog2(CYC_SUM + 1);
  localparam int PCW     = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] LD_SETUP  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] LD_PULSE  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] LD_HOLD   = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] LD_VERIFY = TW'(VERIFY_CYC - 1);

  burn_state_t state_q, state_d;

  logic            tmr_load, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            tally_clr, tally_inc, tally_max;
  logic [PCW-1:0]  tally_cnt;
  logic            start_take, word_take, advance, fail_set;

  logic [AW-1:0]   addr_q;
  logic [AW:0]     remain_q;
  logic [DW-1:0]   data_q;
  logic            ok_q;
  logic [AW-1:0]   fail_addr_q;

  burn_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  burn_tally #(.MAX(MAX_PULSES), .W(PCW)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tally_clr),
    .inc    (tally_inc),
    .count  (tally_cnt),
    .at_max (tally_max)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    tally_clr  = 1'b0;
    tally_inc  = 1'b0;
    start_take = 1'b0;
    word_take  = 1'b0;
    advance    = 1'b0;
    fail_set   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          start_take = 1'b1;
          state_d    = (word_count == '0) ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (src_valid) begin
          word_take = 1'b1;
          tally_clr = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = LD_SETUP;
          state_d   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          tally_inc = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = LD_PULSE;
          state_d   = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = LD_VERIFY;
          state_d  = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        if (tmr_zero) begin
          if (mem_rdata == data_q) begin
            advance = 1'b1;
            state_d = (remain_q == (AW+1)'(1)) ? ST_DONE : ST_FETCH;
          end else if (tally_max) begin
            fail_set = 1'b1;
            state_d  = ST_DONE;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = LD_SETUP;
            state_d  = ST_SETUP;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
    end else if (start_take) begin
      addr_q   <= base_addr;
      remain_q <= word_count;
    end else if (advance) begin
      addr_q   <= addr_q + 1'b1;
      remain_q <= remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (word_take) data_q <= src_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q        <= 1'b0;
      fail_addr_q <= '0;
    end else if (start_take) begin
      ok_q        <= 1'b1;
      fail_addr_q <= '0;
    end else if (fail_set) begin
      ok_q        <= 1'b0;
      fail_addr_q <= addr_q;
    end
  end

  // Output decode
  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);
  assign mem_vpp_hi   = busy && !done;
  assign mem_ce_n     = !mem_vpp_hi;
  assign mem_pgm_n    = (state_q != ST_PULSE);
  assign mem_oe_n     = (state_q != ST_VERIFY);
  assign mem_wdata_en = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign mem_wdata    = data_q;
  assign mem_addr     = addr_q;
  assign src_rd       = (state_q == ST_FETCH);
  assign pass         = ok_q;
  assign fail_addr    = fail_addr_q;

  // Assertions
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_pgm_n && mem_oe_n && mem_ce_n && !mem_vpp_hi && !mem_wdata_en));
  assert_pulse_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (!mem_ce_n && mem_vpp_hi));
  assert_pulse_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_pgm_n && !$past(mem_pgm_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
  assert_pulse_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pgm_n) |-> ($past(mem_wdata_en) && mem_wdata_en));
  assert_verify_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_pgm_n && !mem_wdata_en));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_drops_vpp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_vpp_hi && mem_ce_n));
  assert_fail_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> $past(tally_max));
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(done)) |-> $stable(ok_q) || $past(fail_set));
endmodule

// File: tb/tb_otp_burn_seq.sv
`timescale 1ns/1ps
module tb_otp_burn_seq;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PULSE_CYC = 20;
  localparam int MAXP = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0]   word_count = '0;
  logic          src_rd, src_valid;
  logic [DW-1:0] src_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_wdata_en, mem_ce_n, mem_oe_n, mem_pgm_n, mem_vpp_hi;
  logic          busy, done, pass;
  logic [AW-1:0] fail_addr;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  otp_burn_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(2),
                 .HOLD_CYC(2), .VERIFY_CYC(2), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .src_rd(src_rd), .src_valid(src_valid),
    .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n), .mem_vpp_hi(mem_vpp_hi),
    .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr));

  // Memory and source model
  logic [7:0] pre  [256];
  logic [7:0] need [256];
  logic [7:0] burn [256];
  int         pcnt [256];
  logic [7:0] words [16];
  int         idx;
  logic       mdl_clr = 1'b0;
  logic       prev_pgm;
  int         low_len;
  int         viol;
  logic [AW-1:0] pulse_addr;

  assign src_valid = src_rd;
  assign src_data  = words[idx[3:0]];
  assign mem_rdata = mem_oe_n ? 8'hFF : (pre[mem_addr] & burn[mem_addr]);

  always @(posedge clk) begin
    if (mdl_clr) begin
      for (int i = 0; i < 256; i++) begin
        burn[i] <= 8'hFF;
        pcnt[i] <= 0;
      end
      idx     <= 0;
      viol    <= 0;
      low_len <= 0;
      prev_pgm <= 1'b1;
    end else begin
      prev_pgm <= mem_pgm_n;
      if (src_rd && src_valid) idx <= idx + 1;
      if (!mem_pgm_n) begin
        low_len <= low_len + 1;
        if (prev_pgm) pulse_addr <= mem_addr;
        if (mem_ce_n || !mem_vpp_hi || !mem_oe_n || !mem_wdata_en) viol <= viol + 1;
        if (!prev_pgm && mem_addr != pulse_addr) viol <= viol + 1;
      end else if (!prev_pgm) begin
        if (low_len != PULSE_CYC) viol <= viol + 1;
        low_len <= 0;
        pcnt[mem_addr] <= pcnt[mem_addr] + 1;
        if (pcnt[mem_addr] + 1 >= int'(need[mem_addr]))
          burn[mem_addr] <= burn[mem_addr] & mem_wdata;
      end
      if (!mem_oe_n && mem_wdata_en) viol <= viol + 1;
      if (busy && !done && (mem_ce_n || !mem_vpp_hi)) viol <= viol + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setup_model();
    for (int i = 0; i < 256; i++) begin
      pre[i]  = 8'hFF;
      need[i] = 8'd1;
    end
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
  endtask

  // Launch a run; returns number of done cycles seen and final status.
  task automatic run(input logic [AW-1:0] b, input int cnt, input bit poke,
                     output int dones, output bit ok, output logic [AW-1:0] fa,
                     output bit vpp_at_done, output bit ce_at_done);
    int t = 0;
    dones = 0; ok = 1'b0; fa = '0; vpp_at_done = 1'b1; ce_at_done = 1'b0;
    @(negedge clk);
    start = 1'b1; base_addr = b; word_count = (AW+1)'(cnt);
    @(negedge clk);
    start = 1'b0;
    while (t < 30000) begin
      if (poke && t == 40) begin
        start = 1'b1; base_addr = 8'h80; word_count = 9'd1;
      end
      if (poke && t == 41) start = 1'b0;
      if (done) begin
        dones++; ok = pass; fa = fail_addr;
        vpp_at_done = mem_vpp_hi; ce_at_done = mem_ce_n;
      end
      if (!busy) break;
      @(negedge clk);
      t++;
    end
    chk(t < 30000, "R9", "run timeout", t, 30000);
    repeat (3) begin
      @(negedge clk);
      if (done) dones++;
    end
  endtask

  task automatic test_reset();
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1", "strobes high", {mem_ce_n, mem_oe_n, mem_pgm_n}, 7);
    chk(!mem_vpp_hi && !mem_wdata_en, "R1", "vpp/drive low", {mem_vpp_hi, mem_wdata_en}, 0);
  endtask

  task automatic test_single();
    int d; bit ok; logic [AW-1:0] fa; bit v, c;
    setup_model();
    words[0] = 8'hA5; words[1] = 8'h3C; words[2] = 8'h00; words[3] = 8'hFE;
    run(8'h10, 4, 1'b0, d, ok, fa, v, c);
    chk(d == 1, "R9", "done count", d, 1);
    chk(ok, "R9", "pass", ok, 1);
    chk(!v && c, "R2", "vpp/ce in done cycle", {v, c}, 1);
    for (int i = 0; i < 4; i++) begin
      chk(pcnt[16+i] == 1, "R6", "pulses per word", pcnt[16+i], 1);
      chk(burn[16+i] == words[i], "R12", "word order", burn[16+i], words[i]);
    end
    chk(idx == 4, "R12", "source reads", idx, 4);
    chk(viol == 0, "R3", "pulse shape/stability/verify violations", viol, 0);
  endtask

  task automatic test_multi();
    int d; bit ok; logic [AW-1:0] fa; bit v, c;
    setup_model();
    words[0] = 8'h12; words[1] = 8'h34; words[2] = 8'h56;
    need[8'h20] = 8'd3; need[8'h21] = 8'd7; need[8'h22] = 8'd25;
    run(8'h20, 3, 1'b0, d, ok, fa, v, c);
    chk(ok && d == 1, "R7", "pass with 25th pulse", ok, 1);
    chk(pcnt[8'h20] == 3, "R6", "pulses addr 0x20", pcnt[8'h20], 3);
    chk(pcnt[8'h21] == 7, "R6", "pulses addr 0x21", pcnt[8'h21], 7);
    chk(pcnt[8'h22] == 25, "R7", "pulses addr 0x22", pcnt[8'h22], 25);
    chk(viol == 0, "R5", "pulse/verify violations", viol, 0);
  endtask

  task automatic test_exhaust();
    int d; bit ok; logic [AW-1:0] fa; bit v, c;
    setup_model();
    words[0] = 8'h11; words[1] = 8'h22; words[2] = 8'h33;
    need[8'h41] = 8'd26;
    run(8'h40, 3, 1'b0, d, ok, fa, v, c);
    chk(d == 1 && !ok, "R8", "fail status", ok, 0);
    chk(fa == 8'h41, "R8", "fail_addr", fa, 8'h41);
    chk(pcnt[8'h41] == MAXP, "R7", "pulse cap", pcnt[8'h41], MAXP);
    chk(pcnt[8'h42] == 0 && idx == 2, "R8", "no later address", pcnt[8'h42] + idx, 2);
    chk(!v && c, "R2", "vpp dropped on fail", {v, c}, 1);
  endtask

  task automatic test_conflict();
    int d; bit ok; logic [AW-1:0] fa; bit v, c;
    setup_model();
    words[0] = 8'hF0;
    pre[8'h55] = 8'h0F;
    run(8'h55, 1, 1'b0, d, ok, fa, v, c);
    chk(!ok && fa == 8'h55, "R8", "unreachable 1 bits fail", fa, 8'h55);
    chk(pcnt[8'h55] == MAXP, "R7", "pulses on conflict", pcnt[8'h55], MAXP);
  endtask

  task automatic test_zero();
    int d; bit ok; logic [AW-1:0] fa; bit v, c;
    setup_model();
    run(8'h60, 0, 1'b0, d, ok, fa, v, c);
    chk(d == 1 && ok, "R10", "zero count done+pass", ok, 1);
    chk(idx == 0 && pcnt[8'h60] == 0, "R10", "no reads or pulses", idx + pcnt[8'h60], 0);
  endtask

  task automatic test_busy_start();
    int d; bit ok; logic [AW-1:0] fa; bit v, c;
    setup_model();
    words[0] = 8'h5A; words[1] = 8'hC3;
    need[8'h30] = 8'd2;
    run(8'h30, 2, 1'b1, d, ok, fa, v, c);
    chk(ok && d == 1, "R11", "run unaffected", ok, 1);
    chk(pcnt[8'h80] == 0, "R11", "no pulse at poked base", pcnt[8'h80], 0);
    chk(idx == 2 && burn[8'h31] == 8'hC3, "R11", "source reads", idx, 2);
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) words[i] = 8'hFF;
    for (int i = 0; i < 256; i++) begin
      pre[i] = 8'hFF; need[i] = 8'd1;
    end
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_single();
    test_multi();
    test_exhaust();
    test_conflict();
    test_zero();
    test_busy_start();
    test_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule